// File: doc/BRIEF.md
# Content-Sampled Duplicate Check Gate

This block watches one multi-page write request as its bytes stream in. For every page it keeps the first four bytes and joins them into a 32-bit unsigned number. The page with the largest number is the request's representative. When the request ends, the gate sends only that page's index and value to an external fingerprint checker. It waits for a duplicate or unique verdict and then issues a single decision for the whole request.

When the representative is a duplicate, the decision enables hashing of every page of the request. When it is unique, the decision marks the whole request as unique, so no further fingerprinting is spent on it. The gate takes no new bytes from the end of a request until its decision has been acknowledged. Hash computation lies outside the block.

Top module: `dup_sample_gate`

## Requirements
- R1: After reset `in_ready` is 1, and `chk_req` and `dec_valid` are 0.
- R2: A page's sample value is its first four bytes joined big-endian: the first byte goes to bits 31:24 and the fourth byte to bits 7:0. This value appears on `chk_sample`.
- R3: `chk_page` is the zero-based position, within the request, of the page with the largest unsigned sample value. Pages are counted from the beat that carries `in_first` and starts the request.
- R4: When two or more pages share the largest sample value, the earliest of them is reported.
- R5: A request made of a single page reports page 0 and that page's sample value.
- R6: `chk_req` rises in the cycle after the beat that carries `in_last`. From then until the cycle after `chk_ack`, it stays high with a stable `chk_page` and `chk_sample`, and `in_ready` stays 0.
- R7: If `chk_dup` is 1 when `chk_ack` is taken, the next cycle shows `dec_valid`=1 and `dec_hash_all`=1, meaning every page is to be hashed.
- R8: If `chk_dup` is 0 when `chk_ack` is taken, the next cycle shows `dec_valid`=1 and `dec_hash_all`=0, meaning the request is unique and fingerprinting is skipped.
- R9: `dec_valid` and `dec_hash_all` hold until `dec_ack`. `in_ready` stays 0 until the cycle after `dec_ack`, when `dec_valid` drops and `in_ready` returns to 1.
- R10: Bytes after the fourth byte of a page have no effect on `chk_sample` or `chk_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat valid |
| in_byte | input | BYTE_W | Stream byte |
| in_first | input | 1 | Beat is the first byte of a page |
| in_last | input | 1 | Beat is the last byte of the request |
| in_ready | output | 1 | Gate accepts beats |
| chk_req | output | 1 | Query to the fingerprint checker |
| chk_page | output | IDX_W | Index of the representative page |
| chk_sample | output | 4*BYTE_W | Sample value of the representative page |
| chk_ack | input | 1 | Checker verdict is valid |
| chk_dup | input | 1 | Verdict: the representative is a duplicate |
| dec_valid | output | 1 | Request decision valid |
| dec_hash_all | output | 1 | 1 means hash all pages, 0 means the request is unique |
| dec_ack | input | 1 | Decision consumed |

## Verification
The assertions rely on the following input rules:
- `in_valid` is raised only while `in_ready` is high.
- `chk_ack` is raised only while `chk_req` is high.
- `dec_ack` is raised only while `dec_valid` is high.
- Every page carries at least four bytes.
- A request has no more than 2^IDX_W pages.

The bench keeps to these rules. It drives each page with four to six bytes, all beats after the fourth being 0xFF. It answers the query and the decision only while they are pending, after a variable wait. It sends up to five pages per request, well below the page limit. It sweeps the page counts and several value patterns chosen to produce ties and top-byte contrasts.

// File: rtl/dup_sample_gate.sv
module dup_sample_gate #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_byte,
  input  logic                in_first,
  input  logic                in_last,
  output logic                in_ready,
  output logic                chk_req,
  output logic [IDX_W-1:0]    chk_page,
  output logic [4*BYTE_W-1:0] chk_sample,
  input  logic                chk_ack,
  input  logic                chk_dup,
  output logic                dec_valid,
  output logic                dec_hash_all,
  input  logic                dec_ack
);
  localparam int SAMP_W = 4 * BYTE_W;

  typedef enum logic [1:0] {S_COLLECT, S_CHECK, S_DECIDE} state_t;
  state_t st;

  logic [SAMP_W-1:0] cur, best;
  logic [IDX_W-1:0]  pg, best_pg;
  logic [2:0]        bcnt;
  logic              started, have, dup_q;

  wire beat = in_valid && (st == S_COLLECT);
  wire [SAMP_W-1:0] samp_now = {cur[SAMP_W-BYTE_W-1:0], in_byte};
  wire take   = beat && !in_first && (bcnt == 3'd3);
  wire better = !have || (samp_now > best);

  assign in_ready     = (st == S_COLLECT);
  assign chk_req      = (st == S_CHECK);
  assign chk_page     = best_pg;
  assign chk_sample   = best;
  assign dec_valid    = (st == S_DECIDE);
  assign dec_hash_all = dup_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_COLLECT;
      cur     <= '0;
      best    <= '0;
      pg      <= '0;
      best_pg <= '0;
      bcnt    <= '0;
      started <= 1'b0;
      have    <= 1'b0;
      dup_q   <= 1'b0;
    end else begin
      case (st)
        S_COLLECT: if (beat) begin
          if (in_first) begin
            bcnt <= 3'd1;
            cur  <= {{(SAMP_W-BYTE_W){1'b0}}, in_byte};
            pg   <= started ? pg + 1'b1 : '0;
            started <= 1'b1;
          end else if (bcnt < 3'd4) begin
            bcnt <= bcnt + 3'd1;
            cur  <= samp_now;
          end
          if (take && better) begin
            best    <= samp_now;
            best_pg <= pg;
            have    <= 1'b1;
          end
          if (in_last) st <= S_CHECK;
        end
        S_CHECK: if (chk_ack) begin
          dup_q <= chk_dup;
          st    <= S_DECIDE;
        end
        S_DECIDE: if (dec_ack) begin
          st      <= S_COLLECT;
          started <= 1'b0;
          have    <= 1'b0;
        end
        default: st <= S_COLLECT;
      endcase
    end
  end
endmodule

module dup_sample_gate_chk #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                chk_req,
  input logic [IDX_W-1:0]    chk_page,
  input logic [4*BYTE_W-1:0] chk_sample,
  input logic                chk_ack,
  input logic                chk_dup,
  input logic                dec_valid,
  input logic                dec_hash_all,
  input logic                dec_ack
);
  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && !chk_ack |=> chk_req && $stable(chk_page) && $stable(chk_sample));
  p_busy_chk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> !in_ready);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_req && dec_valid));
  p_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && chk_ack && chk_dup |=> dec_valid && dec_hash_all);
  p_uniq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && chk_ack && !chk_dup |=> dec_valid && !dec_hash_all);
  p_hold_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ack |=> dec_valid && $stable(dec_hash_all));
  p_busy_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !in_ready);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ack |=> in_ready && !dec_valid);
endmodule

bind dup_sample_gate dup_sample_gate_chk #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .chk_req(chk_req),
  .chk_page(chk_page), .chk_sample(chk_sample), .chk_ack(chk_ack),
  .chk_dup(chk_dup), .dec_valid(dec_valid), .dec_hash_all(dec_hash_all),
  .dec_ack(dec_ack));

// File: tb/tb_dup_sample_gate.sv
module tb_dup_sample_gate;
  localparam int CLK_P = 10;
  localparam int IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [7:0] in_byte = 0;
  logic in_ready, chk_req, dec_valid, dec_hash_all;
  logic [IDX_W-1:0] chk_page;
  logic [31:0] chk_sample;
  logic chk_ack = 0, chk_dup = 0, dec_ack = 0;

  int checks = 0, fails = 0;
  logic [31:0] vals [8];

  always #(CLK_P/2) clk = ~clk;

  dup_sample_gate #(.BYTE_W(8), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_first(in_first), .in_last(in_last), .in_ready(in_ready),
    .chk_req(chk_req), .chk_page(chk_page), .chk_sample(chk_sample),
    .chk_ack(chk_ack), .chk_dup(chk_dup), .dec_valid(dec_valid),
    .dec_hash_all(dec_hash_all), .dec_ack(dec_ack));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input int np, input int k, input bit dup);
    int exp_pg = 0;
    logic [31:0] exp_v = vals[0];
    for (int p = 1; p < np; p++)
      if (vals[p] > exp_v) begin exp_v = vals[p]; exp_pg = p; end
    check(in_ready === 1'b1, "R9 ready before request", {31'b0, in_ready}, 1);
    for (int p = 0; p < np; p++) begin
      int nb = 4 + ((p + k) % 3);
      for (int b = 0; b < nb; b++) begin
        @(negedge clk);
        in_valid = 1;
        in_first = (b == 0);
        in_last  = (p == np - 1) && (b == nb - 1);
        in_byte  = (b < 4) ? vals[p][31-8*b -: 8] : 8'hFF;
      end
    end
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0;
    check(chk_req === 1'b1, "R6 query raised", {31'b0, chk_req}, 1);
    check(in_ready === 1'b0, "R6 busy during query", {31'b0, in_ready}, 0);
    check(chk_page === exp_pg[IDX_W-1:0], np == 1 ? "R5 single page index" : "R3 R4 sample page",
          {28'b0, chk_page}, exp_pg);
    check(chk_sample === exp_v, "R2 R10 sample value", chk_sample, exp_v);
    for (int w = 0; w < k % 3; w++) begin
      @(negedge clk);
      check(chk_req === 1'b1 && chk_page === exp_pg[IDX_W-1:0], "R6 query held",
            {28'b0, chk_page}, exp_pg);
    end
    chk_ack = 1; chk_dup = dup;
    @(negedge clk);
    chk_ack = 0; chk_dup = 0;
    check(dec_valid === 1'b1, "R7 R8 decision valid", {31'b0, dec_valid}, 1);
    check(dec_hash_all === dup, dup ? "R7 hash all" : "R8 unique skip", {31'b0, dec_hash_all}, {31'b0, dup});
    check(chk_req === 1'b0, "R6 query dropped", {31'b0, chk_req}, 0);
    for (int w = 0; w < (k + 1) % 3; w++) begin
      @(negedge clk);
      check(dec_valid === 1'b1 && in_ready === 1'b0 && dec_hash_all === dup, "R9 decision held",
            {31'b0, dec_hash_all}, {31'b0, dup});
    end
    dec_ack = 1;
    @(negedge clk);
    dec_ack = 0;
    check(dec_valid === 1'b0 && in_ready === 1'b1, "R9 release",
          {30'b0, dec_valid, in_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && chk_req === 1'b0 && dec_valid === 1'b0, "R1 reset state",
          {29'b0, in_ready, chk_req, dec_valid}, 32'h4);
    rst_n = 1;
    for (int k = 0; k < 6; k++) begin
      for (int np = 1; np <= 5; np++) begin
        for (int p = 0; p < 8; p++) begin
          logic [7:0] top = 8'(((p * (k + 1) + 3) % 4) * 8'h40 + 8'h30);
          if (k % 2 == 1) vals[p] = {top, 24'h123456};
          else vals[p] = {top, 8'(p), 8'(k), 8'h5A};
        end
        if (k == 4) begin vals[0] = 32'h7FFFFFFF; vals[np-1] = 32'h80000000; end
        run_req(np, k, ((k + np) % 2) == 1);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule